// File: doc/BRIEF.md
# Interlacing Framebuffer Scanline Fetcher

The block turns line-timing strobes into read-burst requests for a display pipeline. It holds two line pointers, one per framebuffer. On each line-start strobe it takes the address of the framebuffer that is currently selected, splits the line into fixed-size bursts, and issues one burst per clock. In the same step it adds the stride to that pointer and, in the alternating modes, selects the other framebuffer for the next line.

A 2-bit interlace mode picks how lines are drawn:
- Single buffer: every line comes from framebuffer A.
- Line doubling: both pointers start at base A and the block alternates, so each source line is shown twice.
- Interlace starting at A.
- Interlace starting at B.

A 2-bit burst code picks 32, 64 or 128-byte bursts. The fourth code is not supported; it blanks the output and suppresses all fetches. A pixel-repeat flag is passed through for the pixel stage. All settings are captured on the frame-start strobe, so register writes in the middle of a frame cannot tear the image.

Top module: `fb_line_fetch`

## Requirements
- R1: After reset `burst_valid_o`, `force_black_o`, `fb_sel_o` and `pix_rep_o` are all 0.
- R2: On frame start, pointer A loads base A. Pointer B loads base B, or base A when the mode is 1. The first line comes from framebuffer A (`fb_sel_o`=0), except in mode 3, where it comes from framebuffer B (`fb_sel_o`=1).
- R3: In mode 0 (single buffer), every line comes from framebuffer A, and line n starts at base A + n*stride.
- R4: In modes 2 and 3 (interlace) the framebuffer alternates on every line. Mode 2 starts with A and mode 3 starts with B. Line n starts at its framebuffer's base + floor(n/2)*stride.
- R5: In mode 1 (line doubling), `fb_sel_o` alternates starting with A, and line n starts at base A + floor(n/2)*stride.
- R6: Burst code 0, 1 and 2 give 32, 64 and 128-byte bursts, reported on `burst_len_o`. Within a line, each burst address exceeds the previous one by the burst size.
- R7: A line of L bytes issues ceil(L/size) bursts, one per cycle, in the cycles directly after the line-start edge. L=0 issues none.
- R8: Burst code 3 sets `force_black_o` for the frame and issues no bursts. The pointers still advance on each line.
- R9: `pix_rep_o` shows the pixel-repeat setting captured at the last frame start.
- R10: Changes to bases, stride, mode, burst code, line length and pixel repeat take effect only at the next frame start.
- R11: Frame start overrides a line start in the same cycle, which is then ignored. Frame start also ends any line still issuing bursts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame-start strobe |
| line_start_i | input | 1 | Line-start strobe |
| base_a_i | input | ADDR_W | Framebuffer A base address |
| base_b_i | input | ADDR_W | Framebuffer B base address |
| stride_i | input | ADDR_W | Byte step between source lines |
| mode_i | input | 2 | Interlace mode (0 single, 1 doubling, 2 A-first, 3 B-first) |
| burst_code_i | input | 2 | Burst size code (0:32, 1:64, 2:128, 3:illegal) |
| pix_rep_i | input | 1 | Pixel repeat enable |
| line_bytes_i | input | LEN_W | Bytes fetched per line |
| burst_valid_o | output | 1 | Burst request this cycle |
| burst_addr_o | output | ADDR_W | Burst start address |
| burst_len_o | output | 8 | Burst length in bytes |
| fb_sel_o | output | 1 | Framebuffer of current line (0=A, 1=B) |
| force_black_o | output | 1 | Output blanked by illegal burst code |
| pix_rep_o | output | 1 | Captured pixel repeat flag |

## Verification
The bench sweeps all four modes against all four burst codes, and line lengths that divide exactly, need rounding, and are zero. It predicts every burst address from the arithmetic alone.

It targets these corner cases, each of which a specific bug would break:
- Pointer B loading from the wrong base in doubling mode would show B's image.
- A swapped start field in B-first mode would put the eyes in the wrong order.
- A pointer advancing on the wrong buffer would skip or repeat lines.
- Dropping the round-up would lose the tail of a line.
- Leaving code 3 fetching would show garbage instead of black.
- Mid-frame register scrambling would expose settings that are not captured at frame start.
- A coincident frame/line strobe would leak a stray line if frame start did not override it.
- An abort that does not cut off a line in progress would keep issuing bursts past the frame boundary.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_ALT_A  = 2'd2,
    MODE_ALT_B  = 2'd3
  } ilace_mode_e;

  localparam logic [1:0] BCODE_BAD = 2'd3;

  function automatic logic [7:0] burst_bytes(input logic [1:0] code);
    return 8'd32 << code;
  endfunction
endpackage

// File: rtl/fbf_cfg_latch.sv
module fbf_cfg_latch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        code_i,
  input  logic              rep_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] stride_o,
  output fbf_pkg::ilace_mode_e mode_o,
  output logic [1:0]        code_o,
  output logic              rep_o,
  output logic [LEN_W-1:0]  len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stride_o <= '0;
      mode_o   <= fbf_pkg::MODE_SINGLE;
      code_o   <= '0;
      rep_o    <= 1'b0;
      len_o    <= '0;
    end else if (frame_i) begin
      stride_o <= stride_i;
      mode_o   <= fbf_pkg::ilace_mode_e'(mode_i);
      code_o   <= code_i;
      rep_o    <= rep_i;
      len_o    <= len_i;
    end
  end
endmodule

// File: rtl/fbf_ptr_ctrl.sv
module fbf_ptr_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_i,
  input  logic                 line_i,
  input  logic [ADDR_W-1:0]    base_a_i,
  input  logic [ADDR_W-1:0]    base_b_i,
  input  logic [1:0]           mode_raw_i,
  input  fbf_pkg::ilace_mode_e mode_q_i,
  input  logic [ADDR_W-1:0]    stride_q_i,
  output logic [ADDR_W-1:0]    line_addr_o,
  output logic                 line_sel_o
);
  import fbf_pkg::*;

  logic [ADDR_W-1:0] ptr_a_q, ptr_b_q;
  logic              sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_a_q <= '0;
      ptr_b_q <= '0;
      sel_q   <= 1'b0;
    end else if (frame_i) begin
      ptr_a_q <= base_a_i;
      ptr_b_q <= (mode_raw_i == MODE_DOUBLE) ? base_a_i : base_b_i;
      sel_q   <= (mode_raw_i == MODE_ALT_B);
    end else if (line_i) begin
      if (sel_q) ptr_b_q <= ptr_b_q + stride_q_i;
      else       ptr_a_q <= ptr_a_q + stride_q_i;
      if (mode_q_i != MODE_SINGLE) sel_q <= ~sel_q;
    end
  end

  assign line_addr_o = sel_q ? ptr_b_q : ptr_a_q;
  assign line_sel_o  = sel_q;

  a_r3_single_holds_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i == MODE_SINGLE && !frame_i) |=> $stable(sel_q));
  a_r4_alt_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !frame_i && mode_q_i != MODE_SINGLE) |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/fbf_burst_gen.sv
module fbf_burst_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              line_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              line_sel_i,
  input  logic [1:0]        code_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        len_o,
  output logic              sel_o
);
  import fbf_pkg::*;

  localparam int CNT_W = LEN_W + 1;

  logic [7:0]        bsize;
  logic [CNT_W-1:0]  rounded, n_bursts, left_q;
  logic [ADDR_W-1:0] cur_q;
  logic              sel_q;

  assign bsize    = burst_bytes(code_i);
  assign rounded  = {1'b0, len_i} + CNT_W'(bsize) - CNT_W'(1);
  assign n_bursts = (code_i == BCODE_BAD) ? '0 : (rounded >> (3'd5 + {1'b0, code_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      left_q <= '0;
      sel_q  <= 1'b0;
    end else if (frame_i) begin
      left_q <= '0;
    end else if (line_i) begin
      cur_q  <= line_addr_i;
      left_q <= n_bursts;
      sel_q  <= line_sel_i;
    end else if (left_q != '0) begin
      cur_q  <= cur_q + ADDR_W'(bsize);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign valid_o = (left_q != '0);
  assign addr_o  = cur_q;
  assign len_o   = bsize;
  assign sel_o   = sel_q;
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        burst_code_i,
  input  logic              pix_rep_i,
  input  logic [LEN_W-1:0]  line_bytes_i,
  output logic              burst_valid_o,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [7:0]        burst_len_o,
  output logic              fb_sel_o,
  output logic              force_black_o,
  output logic              pix_rep_o
);
  import fbf_pkg::*;

  logic              line_go;
  logic [ADDR_W-1:0] stride_q, line_addr;
  ilace_mode_e       mode_q;
  logic [1:0]        code_q;
  logic [LEN_W-1:0]  len_q;
  logic              line_sel;

  assign line_go = line_start_i & ~frame_start_i;

  fbf_cfg_latch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk_i, .rst_ni,
    .frame_i  (frame_start_i),
    .stride_i (stride_i),
    .mode_i   (mode_i),
    .code_i   (burst_code_i),
    .rep_i    (pix_rep_i),
    .len_i    (line_bytes_i),
    .stride_o (stride_q),
    .mode_o   (mode_q),
    .code_o   (code_q),
    .rep_o    (pix_rep_o),
    .len_o    (len_q)
  );

  fbf_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni,
    .frame_i     (frame_start_i),
    .line_i      (line_go),
    .base_a_i    (base_a_i),
    .base_b_i    (base_b_i),
    .mode_raw_i  (mode_i),
    .mode_q_i    (mode_q),
    .stride_q_i  (stride_q),
    .line_addr_o (line_addr),
    .line_sel_o  (line_sel)
  );

  fbf_burst_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
    .clk_i, .rst_ni,
    .frame_i     (frame_start_i),
    .line_i      (line_go),
    .line_addr_i (line_addr),
    .line_sel_i  (line_sel),
    .code_i      (code_q),
    .len_i       (len_q),
    .valid_o     (burst_valid_o),
    .addr_o      (burst_addr_o),
    .len_o       (burst_len_o),
    .sel_o       (fb_sel_o)
  );

  assign force_black_o = (code_q == BCODE_BAD);

  a_r8_black_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_black_o |-> !burst_valid_o);
  a_r11_frame_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !burst_valid_o);
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_valid_o && !line_start_i && !frame_start_i) |=>
      (!burst_valid_o || burst_addr_o == $past(burst_addr_o) + ADDR_W'(burst_len_o)));
endmodule

// File: tb/fb_line_fetch_test.sv
`timescale 1ns/1ps
module fb_line_fetch_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam logic [31:0] BA = 32'h0001_0000;
  localparam logic [31:0] BB = 32'h0008_0000;
  localparam logic [31:0] ST = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_s = 1'b0, line_s = 1'b0;
  logic [ADDR_W-1:0] base_a = '0, base_b = '0, stride = '0;
  logic [1:0] mode = '0, code = '0;
  logic rep = 1'b0;
  logic [LEN_W-1:0] lbytes = '0;
  logic valid, sel, black, rep_o;
  logic [ADDR_W-1:0] addr;
  logic [7:0] blen;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fb_line_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .frame_start_i(frame_s), .line_start_i(line_s),
    .base_a_i(base_a), .base_b_i(base_b), .stride_i(stride),
    .mode_i(mode), .burst_code_i(code), .pix_rep_i(rep), .line_bytes_i(lbytes),
    .burst_valid_o(valid), .burst_addr_o(addr), .burst_len_o(blen),
    .fb_sel_o(sel), .force_black_o(black), .pix_rep_o(rep_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic start_frame(input logic [1:0] m, input logic [1:0] c, input logic r,
                             input logic [LEN_W-1:0] lb);
    @(negedge clk);
    base_a = BA; base_b = BB; stride = ST;
    mode = m; code = c; rep = r; lbytes = lb;
    frame_s = 1'b1;
    @(negedge clk);
    frame_s = 1'b0;
    // R10: scramble every setting after capture
    base_a = 32'hDEAD_0000; base_b = 32'hBEEF_0000; stride = 32'h10;
    mode = ~m; code = c ^ 2'd1; rep = ~r; lbytes = 12'd4000;
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [1:0] c, input logic [LEN_W-1:0] lb);
    int size, nb;
    logic r;
    r = m[0] ^ c[0];
    size = 32 << c;
    nb = (c == 2'd3) ? 0 : (int'(lb) + size - 1) / size;
    start_frame(m, c, r, lb);
    chk("R9 pix_rep", rep_o, r);
    chk("R8 force_black", black, c == 2'd3);
    for (int l = 0; l < 5; l++) begin
      logic es;
      logic [31:0] base, k;
      es = (m == 2'd0) ? 1'b0 : (m == 2'd3) ? ~l[0] : l[0];
      k = (m == 2'd0) ? l : l / 2;
      base = ((m >= 2'd2) && es) ? BB : BA;
      line_s = 1'b1;
      @(negedge clk);
      line_s = 1'b0;
      for (int i = 0; i < nb; i++) begin
        chk("R7 valid", valid, 1'b1);
        chk("R3/R4/R5 addr", addr, base + k * ST + i * size);
        chk("R6 len", blen, size);
        chk("R2/R4/R5 sel", sel, es);
        @(negedge clk);
      end
      chk("R7 end of line", valid, 1'b0);
      if (c == 2'd3) chk("R8 black", black, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", valid, 1'b0);
    chk("R1 black", black, 1'b0);
    chk("R1 sel", sel, 1'b0);
    chk("R1 rep", rep_o, 1'b0);

    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++) begin
        run_frame(2'(m), 2'(c), 12'd100);
        run_frame(2'(m), 2'(c), 12'd256);
        run_frame(2'(m), 2'(c), 12'd0);
      end

    // R11: abort a line in progress
    start_frame(2'd0, 2'd0, 1'b0, 12'd256);
    line_s = 1'b1;
    @(negedge clk);
    line_s = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 mid-line valid", valid, 1'b1);
    base_a = BA; base_b = BB; stride = ST; mode = 2'd2; code = 2'd0; lbytes = 12'd64;
    frame_s = 1'b1;
    @(negedge clk);
    chk("R11 abort", valid, 1'b0);
    // R11: coincident strobes, line ignored
    line_s = 1'b1;
    @(negedge clk);
    frame_s = 1'b0; line_s = 1'b0;
    chk("R11 coincident line ignored", valid, 1'b0);
    line_s = 1'b1;
    @(negedge clk);
    line_s = 1'b0;
    chk("R11 first line addr", addr, BA);
    chk("R11 first line sel", sel, 1'b0);
    @(negedge clk);
    chk("R11 second burst", addr, BA + 32);
    @(negedge clk);
    chk("R11 line done", valid, 1'b0);

    done = 1;
    report();
  end
endmodule